// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers four event conditions coming from a converter datapath (ADC clock error, DAC clock error, ADC overflow, ADC underflow) into a status register. Each source has its own trigger mode: it can latch on a rising edge, latch on a falling edge, or track the live level. Latched bits stay set until software reads the status register. A mask register chooses which status bits may drive the interrupt pin, and a polarity bit chooses whether that pin is active high or active low.

A separate overflow pin gives a direct indication of the ADC overflow condition. This pin stays high for a fixed number of clock cycles after the condition goes away, so that a slow observer cannot miss a short overflow. Software reaches the status, mask and mode registers through a simple single-cycle read/write port. Detecting the underlying faults is outside this block: they arrive as input signals.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status, mask and both mode registers read 0, and the polarity bit is 0. As a result `irq_o` is 1 (idle level for active low) and `ovfl_o` is 0 while no event is present.
- R2: Reading address 0x0D returns the status bits in bits 3:0 and 0 in bits 7:4. The status bits are bit 3 = ADC clock error (`evt_i[3]`), bit 2 = DAC clock error (`evt_i[2]`), bit 1 = ADC overflow (`evt_i[1]`) and bit 0 = ADC underflow (`evt_i[0]`).
- R3: In mode 00 (rising), a 0-to-1 change of `evt_i[i]` between two clock edges sets status bit i at the second edge. The bit stays set after the source returns to 0.
- R4: In mode 01 (falling), a 1-to-0 change of `evt_i[i]` sets status bit i at the edge where the 0 is sampled. The bit stays set afterwards.
- R5: In mode 10 or 11 (level), status bit i equals the `evt_i[i]` value sampled at the previous edge, and a status read does not clear it.
- R6: A read of 0x0D (`reg_rd_i` high) clears every edge-mode status bit at the end of that cycle. An edge detected in the same cycle leaves its bit set.
- R7: The mode of source i is {bit i of register 0x0F, bit i of register 0x10}: 0x0F holds the upper mode bit and 0x10 holds the lower mode bit. Both registers read back their bits 3:0, with 0 in bits 7:4.
- R8: Register 0x0E bits 3:0 form the mask. The interrupt is active exactly when some status bit and its mask bit are both 1.
- R9: Bit 7 of register 0x0E sets the polarity. When it is 1, `irq_o` is 1 while the interrupt is active. When it is 0, `irq_o` is 0 while the interrupt is active. Register 0x0E reads back the mask and the polarity bit, with 0 elsewhere.
- R10: `ovfl_o` is 1 in every cycle in which `evt_i[1]` is 1. After the last cycle in which `evt_i[1]` was 1, `ovfl_o` stays 1 for exactly HOLD_CYC more cycles and then goes to 0.
- R11: Writes to 0x0D and to unused addresses change nothing. Reads of unused addresses return 0, and `reg_rdata_o` is 0 whenever `reg_rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Event conditions from the datapath |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt pin, with programmable polarity |
| ovfl_o | output | 1 | Stretched overflow indication |

## Verification
The bench builds the block with N_SRC = 4 and HOLD_CYC = 5, which is short enough to watch the whole overflow stretch end to end. It also lets a new overflow pulse arrive while the stretch counter is still running. With four sources, every mode from the two mode registers can be placed on a different source at the same time. This allows the bench to check that rising, falling and level sources do not affect each other when they share a single status read. A random phase mixes events, reads and register writes in the same cycles. This exercises the case where a read and an edge meet in one cycle, and the case where a mode changes on the same edge that updates the status.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE    = 2'b00,
    TRIG_FALL    = 2'b01,
    TRIG_LVL     = 2'b10,
    TRIG_LVL_ALT = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  logic       prev_i,
  input  trig_mode_e mode_i,
  input  logic       clr_i,
  output logic       stat_o
);
  logic hit;

  always_comb begin
    unique case (mode_i)
      TRIG_RISE: hit = evt_i & ~prev_i;
      TRIG_FALL: hit = ~evt_i & prev_i;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_o <= 1'b0;
    else if (mode_i[1]) stat_o <= evt_i;
    else                stat_o <= (stat_o & ~clr_i) | hit;  // new edge wins over clear
  end
endmodule

// File: rtl/ovfl_hold.sv
module ovfl_hold #(
  parameter int unsigned HOLD_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (live_i)       cnt_q <= CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = live_i | (cnt_q != '0);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned N_SRC        = 4,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned HOLD_CYC     = 4096,
  parameter int unsigned OVFL_IDX     = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR    = 8'h0D,
  parameter logic [ADDR_W-1:0] MASK_ADDR    = 8'h0E,
  parameter logic [ADDR_W-1:0] MODE_HI_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] MODE_LO_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              ovfl_o
);
  localparam int unsigned POL_BIT = DATA_W - 1;

  logic [N_SRC-1:0] evt_q, status_q, mask_q, mode_msb_q, mode_lsb_q;
  logic             pol_q;
  logic             rd_stat, irq_act;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign rd_stat = reg_rd_i && (reg_addr_i == STAT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q      <= '0;
      mask_q     <= '0;
      pol_q      <= 1'b0;
      mode_msb_q <= '0;
      mode_lsb_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (reg_wr_i) begin
        if (reg_addr_i == MASK_ADDR) begin
          mask_q <= reg_wdata_i[N_SRC-1:0];
          pol_q  <= reg_wdata_i[POL_BIT];
        end
        if (reg_addr_i == MODE_HI_ADDR) mode_msb_q <= reg_wdata_i[N_SRC-1:0];
        if (reg_addr_i == MODE_LO_ADDR) mode_lsb_q <= reg_wdata_i[N_SRC-1:0];
      end
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[g]),
      .prev_i (evt_q[g]),
      .mode_i (trig_mode_e'({mode_msb_q[g], mode_lsb_q[g]})),
      .clr_i  (rd_stat),
      .stat_o (status_q[g])
    );
  end

  ovfl_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (evt_i[OVFL_IDX]),
    .hold_o (ovfl_o)
  );

  assign irq_act = |(status_q & mask_q);
  assign irq_o   = pol_q ? irq_act : ~irq_act;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (reg_addr_i == STAT_ADDR) reg_rdata_o[N_SRC-1:0] = status_q;
      if (reg_addr_i == MASK_ADDR) begin
        reg_rdata_o[N_SRC-1:0] = mask_q;
        reg_rdata_o[POL_BIT]   = pol_q;
      end
      if (reg_addr_i == MODE_HI_ADDR) reg_rdata_o[N_SRC-1:0] = mode_msb_q;
      if (reg_addr_i == MODE_LO_ADDR) reg_rdata_o[N_SRC-1:0] = mode_lsb_q;
    end
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OVFL_IDX = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  evt_i,
  input logic [N_SRC-1:0]  evt_q,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  mode_msb_q,
  input logic [N_SRC-1:0]  mode_lsb_q,
  input logic              pol_q,
  input logic              irq_o,
  input logic              ovfl_o
);
  assert_ovfl_live_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[OVFL_IDX] |-> ovfl_o);

  assert_ovfl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(evt_i[OVFL_IDX]) && $past(rst_ni)) |-> ovfl_o);

  assert_mask_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (irq_o == !pol_q));

  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_wr_i && reg_addr_i == STAT_ADDR && mode_msb_q == '0 &&
     mode_lsb_q == '0 && evt_i == '0) |=> (status_q == '0));

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    assert_rise_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_msb_q[g] && !mode_lsb_q[g] && evt_i[g] && !evt_q[g]) |=> status_q[g]);

    assert_fall_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_msb_q[g] && mode_lsb_q[g] && !evt_i[g] && evt_q[g]) |=> status_q[g]);

    assert_level_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mode_msb_q[g]) && $past(rst_ni)) |-> (status_q[g] == $past(evt_i[g])));
  end
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .OVFL_IDX(OVFL_IDX), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .evt_q(evt_q),
  .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .status_q(status_q), .mask_q(mask_q), .mode_msb_q(mode_msb_q),
  .mode_lsb_q(mode_lsb_q), .pol_q(pol_q), .irq_o(irq_o), .ovfl_o(ovfl_o)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;
  localparam int HOLD = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] evt = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq, ovfl;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit m_st[4], m_prev[4], m_mask[4], m_hi[4], m_lo[4];
  bit m_pol;
  int m_cnt;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.N_SRC(4), .HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .ovfl_o(ovfl)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic rd, input logic wr,
                      input logic [7:0] ad, input logic [7:0] wd, input string tag);
    logic [7:0] e_rd;
    bit act;
    @(negedge clk);
    evt = ev; reg_rd = rd; reg_wr = wr; addr = ad; wdata = wd;
    #1;
    act = 0;
    for (int i = 0; i < 4; i++) if (m_st[i] && m_mask[i]) act = 1;
    e_rd = 8'h00;
    if (rd) begin
      for (int i = 0; i < 4; i++) begin
        if (ad == 8'h0D) e_rd[i] = m_st[i];
        if (ad == 8'h0E) e_rd[i] = m_mask[i];
        if (ad == 8'h0F) e_rd[i] = m_hi[i];
        if (ad == 8'h10) e_rd[i] = m_lo[i];
      end
      if (ad == 8'h0E) e_rd[7] = m_pol;
    end
    check({7'd0, irq}, {7'd0, m_pol ? act : !act}, tag, "irq_o");
    check({7'd0, ovfl}, {7'd0, (ev[1] || m_cnt > 0)}, tag, "ovfl_o");
    check(rdata, e_rd, tag, "rdata");
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (m_hi[i]) m_st[i] = ev[i];
      else begin
        if (rd && ad == 8'h0D) m_st[i] = 0;
        if (!m_lo[i] && ev[i] && !m_prev[i]) m_st[i] = 1;
        if (m_lo[i] && !ev[i] && m_prev[i]) m_st[i] = 1;
      end
      m_prev[i] = ev[i];
    end
    if (wr) begin
      for (int i = 0; i < 4; i++) begin
        if (ad == 8'h0E) m_mask[i] = wd[i];
        if (ad == 8'h0F) m_hi[i] = wd[i];
        if (ad == 8'h10) m_lo[i] = wd[i];
      end
      if (ad == 8'h0E) m_pol = wd[7];
    end
    if (ev[1]) m_cnt = HOLD;
    else if (m_cnt > 0) m_cnt--;
  endtask

  task automatic idle(input logic [3:0] ev, input string tag);
    step(ev, 0, 0, 8'h00, 8'h00, tag);
  endtask
  task automatic rd_reg(input logic [7:0] ad, input logic [3:0] ev, input string tag);
    step(ev, 1, 0, ad, 8'h00, tag);
  endtask
  task automatic wr_reg(input logic [7:0] ad, input logic [7:0] d, input string tag);
    step(evt, 0, 1, ad, d, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 4; i++) begin
      m_st[i] = 0; m_prev[i] = 0; m_mask[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
    end
    m_pol = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R1", "irq_o in reset");
    check({7'd0, ovfl}, 8'h00, "R1", "ovfl_o in reset");
    rst_ni = 1'b1;

    // R1 register reset values
    rd_reg(8'h0D, 4'h0, "R1"); rd_reg(8'h0E, 4'h0, "R1");
    rd_reg(8'h0F, 4'h0, "R1"); rd_reg(8'h10, 4'h0, "R1");

    // R11 read-only status, unused addresses
    wr_reg(8'h0D, 8'hFF, "R11"); rd_reg(8'h0D, 4'h0, "R11");
    wr_reg(8'h22, 8'hFF, "R11"); rd_reg(8'h22, 4'h0, "R11");
    rd_reg(8'h0E, 4'h0, "R11"); rd_reg(8'h0F, 4'h0, "R11");
    step(4'h0, 0, 0, 8'h0D, 8'h00, "R11");

    // R2 R3 rising edges per bit, active-high interrupt
    wr_reg(8'h0E, 8'h8F, "R9");
    rd_reg(8'h0E, 4'h0, "R9");
    for (int i = 0; i < 4; i++) begin
      idle(4'(1 << i), "R3");
      idle(4'h0, "R3"); idle(4'h0, "R3");
      rd_reg(8'h0D, 4'h0, "R2");
      idle(4'h0, "R6");
      rd_reg(8'h0D, 4'h0, "R6");
      repeat (HOLD) idle(4'h0, "R10");
    end

    // R4 falling mode
    wr_reg(8'h10, 8'h0F, "R7");
    rd_reg(8'h10, 4'h0, "R7");
    idle(4'hF, "R4"); idle(4'hF, "R4"); rd_reg(8'h0D, 4'hF, "R4");
    idle(4'h0, "R4"); idle(4'h0, "R4");
    rd_reg(8'h0D, 4'h0, "R4"); rd_reg(8'h0D, 4'h0, "R6");

    // R5 level mode
    wr_reg(8'h0F, 8'h0F, "R7"); wr_reg(8'h10, 8'h00, "R7");
    idle(4'h5, "R5"); rd_reg(8'h0D, 4'h5, "R5"); rd_reg(8'h0D, 4'hA, "R5");
    rd_reg(8'h0D, 4'hA, "R5"); rd_reg(8'h0D, 4'h0, "R5"); rd_reg(8'h0D, 4'h0, "R5");
    wr_reg(8'h10, 8'h0F, "R5"); idle(4'h9, "R5"); rd_reg(8'h0D, 4'h9, "R5");

    // R6 read meets edge
    wr_reg(8'h0F, 8'h00, "R6"); wr_reg(8'h10, 8'h00, "R6");
    idle(4'h0, "R6"); rd_reg(8'h0D, 4'h0, "R6");
    idle(4'h1, "R6"); idle(4'h0, "R6");
    rd_reg(8'h0D, 4'h4, "R6"); rd_reg(8'h0D, 4'h0, "R6"); rd_reg(8'h0D, 4'h0, "R6");

    // R7 mixed modes: bit2 level, bit1 falling, bits 0,3 rising
    wr_reg(8'h0F, 8'h04, "R7"); wr_reg(8'h10, 8'h02, "R7");
    idle(4'hF, "R7"); idle(4'hF, "R7"); rd_reg(8'h0D, 4'h0, "R7");
    idle(4'h0, "R7"); rd_reg(8'h0D, 4'h0, "R7"); rd_reg(8'h0D, 4'h0, "R7");
    repeat (HOLD) idle(4'h0, "R10");

    // R8 masking, R9 polarity
    wr_reg(8'h0F, 8'h00, "R8"); wr_reg(8'h10, 8'h00, "R8");
    rd_reg(8'h0D, 4'h0, "R8");
    wr_reg(8'h0E, 8'h82, "R8");
    idle(4'h1, "R8"); idle(4'h0, "R8"); idle(4'h0, "R8");
    idle(4'h2, "R8"); idle(4'h0, "R8"); idle(4'h0, "R8");
    wr_reg(8'h0E, 8'h02, "R9"); idle(4'h0, "R9"); rd_reg(8'h0E, 4'h0, "R9");
    rd_reg(8'h0D, 4'h0, "R9"); idle(4'h0, "R9");
    wr_reg(8'h0E, 8'h00, "R8"); idle(4'h8, "R8"); idle(4'h0, "R8");
    repeat (HOLD) idle(4'h0, "R10");

    // R10 overflow stretch, retrigger during hold
    repeat (3) idle(4'h2, "R10");
    repeat (3) idle(4'h0, "R10");
    idle(4'h2, "R10");
    repeat (HOLD + 3) idle(4'h0, "R10");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] ad;
      int sel;
      sel = $urandom_range(0, 4);
      ad = (sel == 0) ? 8'h0D : (sel == 1) ? 8'h0E : (sel == 2) ? 8'h0F :
           (sel == 3) ? 8'h10 : 8'h22;
      step(($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : evt,
           $urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0, ad,
           8'($urandom_range(0, 255)), "R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule